// File: doc/BRIEF.md
# Dual-Window Watchdog Supervisor

This block supervises a microprocessor through a periodic trigger. Each watchdog window opens with a closed span, in which a trigger is not allowed, and continues with an open span, in which the processor must trigger. A correct trigger restarts the window. A trigger that comes too early, or no trigger at all, makes the block drive a fixed-length active-low reset pulse. Two window lengths exist. The long one is used after power-on and after every reset pulse. A mode input picks the long or the short length, and the choice is taken each time a correct trigger restarts the window.

A peripheral enable output turns on only after three correct triggers in a row with no fault between them. A wake-up input is debounced over a parameterised number of cycles. While the long window runs, every accepted level change on it, rising or falling, forces a reset pulse. All periods are counted in cycles of the single clock.

Top module: `dual_window_wdog`

## Requirements
- R1: After power-on reset `rst_out_n` is 1 and `en_o` is 0, and the first window is the long one.
- R2: `trig_i` passes through a two-flop synchroniser. Only a falling edge is a trigger. A low level held for many cycles is a single trigger, and the rising edge that follows counts for nothing.
- R3: A trigger taken while the window count is below the closed length of the current window (CLOSED_LONG or CLOSED_SHORT) is a fault and starts a reset pulse.
- R4: A trigger taken at a window count from the closed length up to closed+open-1 is correct and restarts the window at count 0. If no trigger comes, the count reaching closed+open-1 is a fault. With the input timing used here, a restart followed by no trigger gives a reset exactly CLOSED+OPEN cycles later.
- R5: A reset pulse holds `rst_out_n` at 0 for exactly PULSE_LEN cycles. Triggers are ignored during the pulse, and the next window is the long one.
- R6: `en_o` rises only on the third consecutive correct trigger. It falls in the first cycle of any reset pulse, and counting starts again from zero.
- R7: `mode_i` = 1 selects the short window and `mode_i` = 0 the long one. It is sampled only when a correct trigger restarts the window.
- R8: `wake_i` is accepted at a new level only after its synchronised value has differed from the accepted level for DEBOUNCE consecutive cycles. Shorter glitches are dropped.
- R9: In the long window, every accepted wake-up change, in either direction, starts a reset pulse. It appears on `rst_out_n` DEBOUNCE+2 cycles after the input change.
- R10: In the short window, accepted wake-up changes have no effect on `rst_out_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single time-base clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| trig_i | input | 1 | Processor trigger, falling edge counts |
| mode_i | input | 1 | Window select: 1 short, 0 long |
| wake_i | input | 1 | Wake-up request level, debounced inside |
| rst_out_n | output | 1 | Reset to the processor, active low |
| en_o | output | 1 | Peripheral enable |

## Verification
The bench triggers at the exact edges of the window: the last closed count, the first open count and the last open count. A design off by one at either edge would reset on a good trigger or let an early one through. It also holds the trigger low for many cycles, to expose a design that counts levels or rising edges, since such a design would grant the enable early. It measures the timeout distance, the pulse width and the wake-up delay in cycles, checks that a glitch is rejected, and sends wake-up changes in both directions in each window length. A design that ignored falling wake-up edges, or reset during the short window, would be caught there.

// File: rtl/dual_window_wdog.sv
`timescale 1ns/1ps
module dual_window_wdog #(
  parameter int CLOSED_LONG  = 20,
  parameter int OPEN_LONG    = 40,
  parameter int CLOSED_SHORT = 8,
  parameter int OPEN_SHORT   = 16,
  parameter int PULSE_LEN    = 6,
  parameter int DEBOUNCE     = 4,
  parameter int GOOD_NEEDED  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic mode_i,
  input  logic wake_i,
  output logic rst_out_n,
  output logic en_o
);
  localparam int LONG_LAST  = CLOSED_LONG + OPEN_LONG - 1;
  localparam int SHORT_LAST = CLOSED_SHORT + OPEN_SHORT - 1;
  localparam int MAX_LAST   = (LONG_LAST > SHORT_LAST) ? LONG_LAST : SHORT_LAST;
  localparam int CW = $clog2(MAX_LAST + 1);
  localparam int PW = $clog2(PULSE_LEN + 1);
  localparam int DW = $clog2(DEBOUNCE + 1);
  localparam int GW = $clog2(GOOD_NEEDED + 1);

  logic [2:0]    trig_sh;
  logic [1:0]    wake_sy;
  logic          wake_lvl;
  logic [DW-1:0] deb_cnt;
  logic          in_pulse;
  logic          win_long;
  logic [CW-1:0] win_cnt;
  logic [PW-1:0] pulse_cnt;
  logic [GW-1:0] good_cnt;

  logic          trig_fall, wake_diff, wake_evt;
  logic [CW-1:0] closed_len, last_cnt;
  logic          early, on_time, expired, wake_hit, fault;

  assign trig_fall = trig_sh[2] & ~trig_sh[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) trig_sh <= 3'b111;
    else        trig_sh <= {trig_sh[1:0], trig_i};

  assign wake_diff = wake_sy[1] ^ wake_lvl;
  assign wake_evt  = wake_diff && (deb_cnt == DW'(DEBOUNCE - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wake_sy  <= 2'b00;
      wake_lvl <= 1'b0;
      deb_cnt  <= '0;
    end else begin
      wake_sy <= {wake_sy[0], wake_i};
      if (!wake_diff) deb_cnt <= '0;
      else if (wake_evt) begin
        deb_cnt  <= '0;
        wake_lvl <= wake_sy[1];
      end else deb_cnt <= deb_cnt + 1'b1;
    end

  assign closed_len = win_long ? CW'(CLOSED_LONG) : CW'(CLOSED_SHORT);
  assign last_cnt   = win_long ? CW'(LONG_LAST)   : CW'(SHORT_LAST);
  assign early      = trig_fall && (win_cnt < closed_len);
  assign on_time    = trig_fall && !early;
  assign expired    = !trig_fall && (win_cnt == last_cnt);
  assign wake_hit   = wake_evt && win_long;
  assign fault      = !in_pulse && (early || expired || wake_hit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_pulse  <= 1'b0;
      win_long  <= 1'b1;
      win_cnt   <= '0;
      pulse_cnt <= '0;
      good_cnt  <= '0;
    end else if (in_pulse) begin
      if (pulse_cnt == PW'(PULSE_LEN - 1)) begin
        in_pulse  <= 1'b0;
        pulse_cnt <= '0;
        win_cnt   <= '0;
        win_long  <= 1'b1;
      end else pulse_cnt <= pulse_cnt + 1'b1;
    end else if (fault) begin
      in_pulse  <= 1'b1;
      pulse_cnt <= '0;
      good_cnt  <= '0;
    end else if (on_time) begin
      win_cnt  <= '0;
      win_long <= !mode_i;
      if (good_cnt != GW'(GOOD_NEEDED)) good_cnt <= good_cnt + 1'b1;
    end else win_cnt <= win_cnt + 1'b1;

  assign rst_out_n = !in_pulse;
  assign en_o      = (good_cnt == GW'(GOOD_NEEDED));
endmodule

// File: rtl/dual_window_wdog_chk.sv
`timescale 1ns/1ps
module dual_window_wdog_chk #(
  parameter int PULSE_LEN = 6
) (
  input logic clk,
  input logic rst_n,
  input logic rst_out_n,
  input logic en_o,
  input logic trig_fall,
  input logic win_long,
  input logic wake_evt
);
  int unsigned low_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) low_cnt <= 0;
    else if (!rst_out_n) low_cnt <= low_cnt + 1;
    else low_cnt <= 0;

  p_pulse_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> low_cnt == PULSE_LEN);

  p_long_after_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> win_long);

  p_no_enable_in_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out_n |-> !en_o);

  p_enable_from_trigger_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_o) |-> $past(trig_fall));

  p_wake_long_resets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && win_long && rst_out_n) |=> !rst_out_n);
endmodule

bind dual_window_wdog dual_window_wdog_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_out_n(rst_out_n), .en_o(en_o),
  .trig_fall(trig_fall), .win_long(win_long), .wake_evt(wake_evt)
);

// File: tb/dual_window_wdog_test.sv
`timescale 1ns/1ps
module dual_window_wdog_test;
  localparam int CL = 20, OL = 40, CS = 8, OS = 16, PL = 6, DB = 4;
  localparam int NV = 12;
  localparam int V_GAP [NV] = '{35, 35, 35, 12, 20, 40, 5, 30, 3, 30, 30, 30};
  localparam int V_MODE[NV] = '{0,  0,  1,  1,  0,  0,  0, 1,  1, 0,  0,  0};
  localparam int V_RSTN[NV] = '{1,  1,  1,  1,  1,  1,  0, 1,  0, 1,  1,  1};
  localparam int V_EN  [NV] = '{0,  0,  1,  1,  1,  1,  0, 0,  0, 0,  0,  1};

  logic clk = 1'b0, rst_n = 1'b0, trig_i = 1'b1, mode_i = 1'b0, wake_i = 1'b0;
  logic rst_out_n, en_o;
  int checks = 0, errors = 0, n;
  bit done = 0;

  dual_window_wdog #(.CLOSED_LONG(CL), .OPEN_LONG(OL), .CLOSED_SHORT(CS),
    .OPEN_SHORT(OS), .PULSE_LEN(PL), .DEBOUNCE(DB), .GOOD_NEEDED(3)) uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .mode_i(mode_i), .wake_i(wake_i),
    .rst_out_n(rst_out_n), .en_o(en_o));

  always #10 clk = ~clk;

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_trig(input int gap, input logic m);
    tick(gap);
    mode_i = m;
    trig_i = 1'b0;
    tick(2);
    trig_i = 1'b1;
  endtask

  task automatic wait_pulse_end(input string tag);
    int len = 1;
    while (!rst_out_n && len < 100) begin
      tick(1);
      if (!rst_out_n) len++;
    end
    check(tag, len, PL);
  endtask

  task automatic count_until_low(output int cnt);
    cnt = 0;
    while (rst_out_n && cnt < 500) begin
      tick(1);
      cnt++;
    end
  endtask

  initial begin
    tick(5);
    check("R1 reset output idle", rst_out_n, 1);
    check("R1 enable off", en_o, 0);
    rst_n = 1'b1;

    // R3/R4/R7 table: gap in cycles, mode, expected reset and enable
    for (int i = 0; i < NV; i++) begin
      pulse_trig(V_GAP[i], V_MODE[i]);
      tick(1);
      check($sformatf("R3/R4/R7 vec%0d rst_out_n", i), rst_out_n, V_RSTN[i]);
      check($sformatf("R6 vec%0d en_o", i), en_o, V_EN[i]);
      if (!rst_out_n) wait_pulse_end($sformatf("R5 vec%0d pulse width", i));
    end

    // R4 first open count of the long window
    pulse_trig(CL - 2, 1'b0); tick(1);
    check("R4 first open count", rst_out_n, 1);
    // R3 last closed count
    pulse_trig(CL - 3, 1'b0); tick(1);
    check("R3 last closed count", rst_out_n, 0);
    check("R6 enable dropped", en_o, 0);
    wait_pulse_end("R5 after early trigger");
    // R4 last open count
    pulse_trig(CL + OL - 3, 1'b0); tick(1);
    check("R4 last open count", rst_out_n, 1);
    count_until_low(n);
    check("R4 timeout distance", n, CL + OL);
    wait_pulse_end("R5 after timeout");

    // R2 long low level is a single trigger
    tick(30); trig_i = 1'b0; tick(20); trig_i = 1'b1;
    check("R2 held low no reset", rst_out_n, 1);
    check("R2 held low counted once", en_o, 0);
    pulse_trig(10, 1'b0); tick(1);
    check("R2 second trigger", en_o, 0);
    pulse_trig(30, 1'b0); tick(1);
    check("R2/R6 third trigger grants enable", en_o, 1);

    // R8 glitch, R9 rising and falling wake in long window
    wake_i = 1'b1; tick(2); wake_i = 1'b0; tick(10);
    check("R8 glitch rejected", rst_out_n, 1);
    check("R8 enable kept", en_o, 1);
    wake_i = 1'b1;
    count_until_low(n);
    check("R9 rising wake delay", n, DB + 2);
    check("R6 enable cleared by wake reset", en_o, 0);
    wait_pulse_end("R5 after wake rise");
    wake_i = 1'b0;
    count_until_low(n);
    check("R9 falling wake delay", n, DB + 2);
    wait_pulse_end("R5 after wake fall");

    // R10 wake ignored in short window
    pulse_trig(30, 1'b1); tick(1);
    check("R7 good trigger selects short", rst_out_n, 1);
    wake_i = 1'b1; tick(8);
    check("R10 rising wake ignored", rst_out_n, 1);
    wake_i = 1'b0; tick(8);
    check("R10 falling wake ignored", rst_out_n, 1);
    pulse_trig(2, 1'b1); tick(1);
    check("R10 short window intact", rst_out_n, 1);
    count_until_low(n);
    check("R7 short timeout distance", n, CS + OS);
    wait_pulse_end("R5 after short timeout");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule